// File: doc/BRIEF.md
# Reference Prescaler to 8 kHz Frame Rate

This block divides an incoming reference clock down to a common 8 kHz frame rate. The reference is used directly as the block clock. A joint decode of the rate-family/mode field, the harmonic multiplier field and the master/slave select picks the divide ratio, so the output frame rate is 8 kHz whatever the reference is.

In master forward operation the reference is n times 1.544 MHz or n times 2.048 MHz, with n from 1 to 16. In master reverse operation it is 56 kHz or 64 kHz. In slave operation, and for the two reverse codes that take an 8 kHz reference, every reference cycle is already one frame.

The block drives two outputs. One is a one-cycle frame pulse for the downstream phase comparator. The other is a near-square sync wave that lines up cascaded devices. A configuration change never cuts a frame short: the new ratio is taken only at the end of the frame in progress.

Top module: `frame_prescaler`

## Requirements
- R1: While `rst_n` is low, `frame_tick` and `sync_out` are both 1. The first frame after reset release already uses the ratio decoded from the inputs present at release.
- R2: With `is_master`=1 and `mode_sel[3]`=0, every `mode_sel` code except 4'b0110 and 4'b0111 divides by 193 x n, where n = `mult_sel` + 1 (4'b0000 gives n=1, 4'b1111 gives n=16).
- R3: With `is_master`=1 and `mode_sel[3]`=1, every `mode_sel` code except 4'b1110 and 4'b1111 divides by 256 x n, with n = `mult_sel` + 1.
- R4: With `is_master`=1, `mode_sel`=4'b0110 divides by 7 and `mode_sel`=4'b1111 divides by 8. In both cases `mult_sel` has no effect on the frame length.
- R5: With `is_master`=1, `mode_sel`=4'b0111 or 4'b1110 divides by 1.
- R6: With `is_master`=0, the ratio is 1 whatever `mode_sel` and `mult_sel` hold.
- R7: In a frame of length L>1, `sync_out` is 1 for the first floor(L/2) cycles, starting at the frame-pulse cycle, and 0 for the rest. When L=1, `sync_out` stays 1.
- R8: `frame_tick` is 1 in exactly the first cycle of each frame. The distance between two successive pulses is the frame length.
- R9: A change on `mode_sel`, `mult_sel` or `is_master` affects only frames that start after the current frame ends. The current frame keeps its ratio even if the new ratio is smaller than the count already reached, and a value that is changed back before the frame ends has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fin_clk | input | 1 | Reference clock; also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 4 | Rate family / forward or reverse mode code |
| mult_sel | input | MULT_W (4) | Harmonic multiplier, value n-1 |
| is_master | input | 1 | 1 = master, 0 = slave (8 kHz reference) |
| frame_tick | output | 1 | One-cycle pulse at the start of each 8 kHz frame |
| sync_out | output | 1 | 8 kHz sync wave, high in the first half of each frame |

## Verification
The bench goes after the largest ratios: n=16 in both families, 3088 and 4096 cycles. A decoder that drops the top multiplier bit, or a counter one bit too narrow, would give frames that are far too short. It also moves from a 4096 frame to a 965 ratio deep into the frame, past count 965. A design that applies the change at once would wrap early or run past its terminal compare. A brief excursion to a reverse code inside a frame checks that only the value present at the frame end counts. The bench also walks through the reverse codes with both extreme multiplier values, the 8 kHz reverse codes and slave mode. A wrong decode there would give a frame length other than 7, 8 or 1, or a sync wave that drops low at ratio 1.

// File: rtl/fp_pkg.sv
package fp_pkg;

   typedef logic [3:0] mode_t;

   typedef enum logic [2:0] {
      CLS_FWD_T1,
      CLS_FWD_E1,
      CLS_REV_LOW,
      CLS_REV_HIGH,
      CLS_UNITY
   } ratio_class_e;

   localparam mode_t MODE_REV_LOW  = 4'b0110;
   localparam mode_t MODE_REV_8K_A = 4'b0111;
   localparam mode_t MODE_REV_8K_B = 4'b1110;
   localparam mode_t MODE_REV_HIGH = 4'b1111;

   function automatic ratio_class_e classify(input mode_t m, input logic master);
      ratio_class_e c;
      if (!master) begin
         c = CLS_UNITY;
      end else begin
         case (m)
            MODE_REV_LOW:                 c = CLS_REV_LOW;
            MODE_REV_HIGH:                c = CLS_REV_HIGH;
            MODE_REV_8K_A, MODE_REV_8K_B: c = CLS_UNITY;
            default:                      c = m[3] ? CLS_FWD_E1 : CLS_FWD_T1;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/fp_ratio_decode.sv
module fp_ratio_decode
   import fp_pkg::*;
#(
   parameter int T1_BASE   = 193,
   parameter int E1_BASE   = 256,
   parameter int REV_LOW   = 7,
   parameter int REV_HIGH  = 8,
   parameter int MULT_W    = 4,
   parameter int CNT_W     = 13,
   parameter int MUL_STYLE = 1
) (
   input  mode_t             mode_sel,
   input  logic [MULT_W-1:0] mult_sel,
   input  logic              is_master,
   output logic [CNT_W-1:0]  ratio
);

   ratio_class_e      cls;
   logic [MULT_W:0]   harm;
   logic [CNT_W-1:0]  base;
   logic [CNT_W-1:0]  prod;

   assign cls  = classify(mode_sel, is_master);
   assign harm = {1'b0, mult_sel} + (MULT_W+1)'(1);

   always_comb begin
      case (cls)
         CLS_FWD_E1: base = CNT_W'(E1_BASE);
         default:    base = CNT_W'(T1_BASE);
      endcase
   end

   generate
      if (MUL_STYLE == 0) begin : g_mul_native
         assign prod = base * CNT_W'(harm);
      end else begin : g_mul_shift_add
         always_comb begin
            prod = '0;
            for (int b = 0; b <= MULT_W; b++) begin
               if (harm[b]) prod = prod + (base << b);
            end
         end
      end
   endgenerate

   always_comb begin
      case (cls)
         CLS_FWD_T1, CLS_FWD_E1: ratio = prod;
         CLS_REV_LOW:            ratio = CNT_W'(REV_LOW);
         CLS_REV_HIGH:           ratio = CNT_W'(REV_HIGH);
         default:                ratio = CNT_W'(1);
      endcase
   end

endmodule

// File: rtl/fp_div_counter.sv
module fp_div_counter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] ratio_in,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] ratio_q,
   output logic             frame_start
);

   logic terminal;

   assign terminal    = (cnt == ratio_q - CNT_W'(1));
   assign frame_start = (cnt == '0);

   // ratio_q resets to 1 so the first edge after release is a terminal edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= CNT_W'(1);
      end else if (terminal) begin
         cnt     <= '0;
         ratio_q <= ratio_in;
      end else begin
         cnt     <= cnt + CNT_W'(1);
      end
   end

   p_cnt_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < ratio_q)
      else $error("count reached or passed the held ratio");

   p_ratio_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != ratio_q - CNT_W'(1)) |=> $stable(ratio_q))
      else $error("ratio changed inside a frame");

   p_wrap_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == ratio_q - CNT_W'(1)) |=> (cnt == '0))
      else $error("count did not restart after the terminal cycle");

   p_nonzero_ratio_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_q != '0)
      else $error("zero ratio loaded");

endmodule

// File: rtl/fp_sync_gen.sv
module fp_sync_gen #(
   parameter int CNT_W = 13
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] ratio_q,
   output logic             sync
);

   logic [CNT_W-1:0] half;
   logic             unity;

   assign half  = ratio_q >> 1;
   assign unity = (ratio_q == CNT_W'(1));
   assign sync  = unity | (cnt < half);

endmodule

// File: rtl/frame_prescaler.sv
module frame_prescaler
   import fp_pkg::*;
#(
   parameter int T1_BASE   = 193,
   parameter int E1_BASE   = 256,
   parameter int REV_LOW   = 7,
   parameter int REV_HIGH  = 8,
   parameter int MULT_W    = 4,
   parameter int MUL_STYLE = 1
) (
   input  logic              fin_clk,
   input  logic              rst_n,
   input  logic [3:0]        mode_sel,
   input  logic [MULT_W-1:0] mult_sel,
   input  logic              is_master,
   output logic              frame_tick,
   output logic              sync_out
);

   localparam int N_MAX    = 1 << MULT_W;
   localparam int BASE_MAX = (T1_BASE > E1_BASE) ? T1_BASE : E1_BASE;
   localparam int R_MAX    = BASE_MAX * N_MAX;
   localparam int CNT_W    = $clog2(R_MAX + 1);

   generate
      if (T1_BASE < 2 || E1_BASE < 2) begin : g_bad_base
         $error("forward base ratios must be at least 2");
      end
      if (REV_LOW < 2 || REV_HIGH < 2) begin : g_bad_rev
         $error("reverse ratios must be at least 2");
      end
      if (MULT_W < 1 || MULT_W > 8) begin : g_bad_mult
         $error("MULT_W out of range");
      end
      if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
         $error("MUL_STYLE must be 0 or 1");
      end
   endgenerate

   logic [CNT_W-1:0] ratio_next;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] ratio_q;
   logic             frame_start;

   fp_ratio_decode #(
      .T1_BASE  (T1_BASE),
      .E1_BASE  (E1_BASE),
      .REV_LOW  (REV_LOW),
      .REV_HIGH (REV_HIGH),
      .MULT_W   (MULT_W),
      .CNT_W    (CNT_W),
      .MUL_STYLE(MUL_STYLE)
   ) u_decode (
      .mode_sel (mode_sel),
      .mult_sel (mult_sel),
      .is_master(is_master),
      .ratio    (ratio_next)
   );

   fp_div_counter #(
      .CNT_W(CNT_W)
   ) u_counter (
      .clk        (fin_clk),
      .rst_n      (rst_n),
      .ratio_in   (ratio_next),
      .cnt        (cnt),
      .ratio_q    (ratio_q),
      .frame_start(frame_start)
   );

   fp_sync_gen #(
      .CNT_W(CNT_W)
   ) u_sync (
      .cnt    (cnt),
      .ratio_q(ratio_q),
      .sync   (sync_out)
   );

   assign frame_tick = frame_start;

   p_tick_in_sync_high_r7: assert property (@(posedge fin_clk) disable iff (!rst_n)
      frame_tick |-> sync_out)
      else $error("sync low on a frame pulse");

   p_sync_falls_mid_r7: assert property (@(posedge fin_clk) disable iff (!rst_n)
      (ratio_q > CNT_W'(1) && cnt == (ratio_q >> 1)) |-> !sync_out)
      else $error("sync still high at half frame");

   p_slave_unity_r6: assert property (@(posedge fin_clk) disable iff (!rst_n)
      (cnt == ratio_q - CNT_W'(1) && !is_master) |=> (ratio_q == CNT_W'(1)))
      else $error("slave frame longer than one cycle");

endmodule

// File: tb/test_frame_prescaler.sv
module test_frame_prescaler;

   typedef struct {
      int    ratio;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mode_sel = '0;
   logic [3:0] mult_sel = '0;
   logic       is_master = 1'b1;
   logic       frame_tick;
   logic       sync_out;

   int checks = 0;
   int errors = 0;
   int tick_cnt = 0;
   int target = 0;
   bit mon_en = 0;
   bit started = 0;
   int len = 0;
   int hi = 0;
   exp_t q[$];

   always #4 clk = ~clk;

   frame_prescaler i_frame_prescaler (
      .fin_clk   (clk),
      .rst_n     (rst_n),
      .mode_sel  (mode_sel),
      .mult_sel  (mult_sel),
      .is_master (is_master),
      .frame_tick(frame_tick),
      .sync_out  (sync_out)
   );

   task automatic check_int(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   // monitor: measures each frame and compares with the scoreboard queue
   task automatic close_frame();
      exp_t e;
      int   exp_hi;
      if (q.size() == 0) begin
         checks++;
         errors++;
         $display("FAIL R9 unexpected frame: actual length %0d expected none", len);
      end else begin
         e = q.pop_front();
         exp_hi = (e.ratio == 1) ? 1 : e.ratio / 2;
         check_int({"R8 ", e.tag, " frame length"}, len, e.ratio);
         check_int({"R7 ", e.tag, " sync high cycles"}, hi, exp_hi);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en) begin
         if (frame_tick) begin
            if (started) close_frame();
            started = 1;
            len = 1;
            hi = int'(sync_out);
            tick_cnt++;
         end else if (started) begin
            len++;
            hi += int'(sync_out);
         end
      end
   end

   // driver: push expected frames, then apply settings inside the last old frame
   task automatic push_exp(input int ratio, input int nfr, input string tag);
      for (int i = 0; i < nfr; i++) q.push_back('{ratio, tag});
      target += nfr;
   endtask

   task automatic run_cfg(input logic [3:0] m, input logic [3:0] k, input logic ms,
                          input int ratio, input int nfr, input int dly, input string tag);
      repeat (dly) @(negedge clk);
      #1;
      mode_sel  = m;
      mult_sel  = k;
      is_master = ms;
      push_exp(ratio, nfr, tag);
      wait (tick_cnt >= target);
      #1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      mode_sel  = 4'b0000;
      mult_sel  = 4'b0000;
      is_master = 1'b1;
      repeat (3) @(negedge clk);
      check_int("R1 reset frame_tick", int'(frame_tick), 1);
      check_int("R1 reset sync_out", int'(sync_out), 1);
      push_exp(193, 3, "R1 R2 T1 n=1");
      #1;
      rst_n  = 1'b1;
      mon_en = 1;
      wait (tick_cnt >= target);
      #1;
      run_cfg(4'b1000, 4'b0000, 1'b1, 256,  3, 10,   "R3 E1 n=1");
      run_cfg(4'b0101, 4'b1111, 1'b1, 3088, 2, 50,   "R2 T1 n=16");
      run_cfg(4'b1101, 4'b1111, 1'b1, 4096, 2, 100,  "R3 E1 n=16");
      // new ratio 965 applied at count 3000 of a 4096 frame
      run_cfg(4'b0011, 4'b0100, 1'b1, 965,  2, 3000, "R9 R2 T1 n=5 late change");
      run_cfg(4'b0110, 4'b0000, 1'b1, 7,    4, 0,    "R4 reverse low k=0");
      run_cfg(4'b0110, 4'b1111, 1'b1, 7,    4, 3,    "R4 reverse low k=15");
      run_cfg(4'b1111, 4'b0101, 1'b1, 8,    4, 2,    "R4 reverse high");
      run_cfg(4'b0111, 4'b0011, 1'b1, 1,    4, 5,    "R5 reverse 8k code a");
      run_cfg(4'b1110, 4'b1100, 1'b1, 1,    3, 0,    "R5 reverse 8k code b");
      run_cfg(4'b1000, 4'b1001, 1'b0, 1,    4, 0,    "R6 slave");
      run_cfg(4'b1010, 4'b0010, 1'b1, 768,  2, 0,    "R3 E1 n=3");
      // transient excursion to a reverse code inside the last 768 frame
      repeat (10) @(negedge clk);
      #1;
      mode_sel = 4'b0110;
      repeat (5) @(negedge clk);
      #1;
      mode_sel = 4'b1010;
      run_cfg(4'b0001, 4'b0001, 1'b1, 386,  2, 20,   "R9 R2 T1 n=2");
      target += 1;
      wait (tick_cnt >= target);
      #1;
      check_int("R9 leftover expected frames", q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule